// File: doc/BRIEF.md
# Memory-Mapped ATA Register Bridge

This block sits between a simple host bus slave port and the register port of an ATA drive controller. It claims a 4 KiB address window in which every drive register owns a 16-byte slot. A host access can be 8, 16 or 32 bits wide. The block decodes the access into a strobe toward one of three targets: the task-file registers, the device control and alternate status register, or the data port. Read data from the drive is registered and returned one cycle later, together with a ready pulse.

The host bus and the drive use opposite byte orders. Traffic through the data port is therefore byte-reversed in both directions, at the width of the access. An access that matches no register has no effect on the drive. If such an access is a read, it returns all ones at the access width, so software probing an empty slot sees a floating bus.

The status register is the only register whose read has a side effect. Reading it tells the drive logic to drop its pending interrupt. The control register and the alternate status register share two aliased slots, and reading alternate status leaves the interrupt untouched.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits [3:0] have no effect on decoding, so any address inside a 16-byte slot reaches the same register.
- R2: An 8-bit access (size code 0) at index 1 to 7 is a task-file access. A write pulses `drv_tf_wr` with the byte on `drv_wdata[7:0]`. A read pulses `drv_tf_rd` and returns `drv_tf_rdata` in `bus_rdata[7:0]` with zeros above. In both cases `drv_tf_idx` carries the index.
- R3: An 8-bit read at index 7 (status) pulses `drv_irq_clr` in the same cycle. Reads of indexes 1 to 6 do not.
- R4: An 8-bit write at index 8 or index 22 pulses `drv_ctl_wr` with the byte on `drv_wdata[7:0]`.
- R5: An 8-bit read at index 8 or index 22 returns `drv_altstat` in `bus_rdata[7:0]`. It raises no drive strobe and does not pulse `drv_irq_clr`.
- R6: A 16-bit access (size code 1) at index 0 reaches the data port with `drv_data_wide` low, and its two bytes are swapped in both directions.
  - A write presents `{wdata[7:0], wdata[15:8]}` on `drv_wdata[15:0]`.
  - A read takes `drv_data_rdata[15:0]` and returns it swapped in `bus_rdata[15:0]`, with zeros above.
- R7: A 32-bit access (size code 2) at index 0 reaches the data port with `drv_data_wide` high, and all four bytes are reversed in both directions.
- R8: A read that matches no register returns all ones at the access width in the low bits of `bus_rdata`, with zeros above: 0xFF for 8 bits, 0xFFFF for 16 bits, 0xFFFFFFFF for 32 bits. Size code 3 is never mapped and reads as 32-bit all ones.
- R9: A write that matches no register raises no drive strobe and leaves every drive register unchanged.
- R10: `bus_ready` is high exactly in the cycle after each accepted access, and in that cycle `bus_rdata` holds the read result. One access can be accepted every cycle. After reset `bus_ready` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_size | input | 2 | Access width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = reserved |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data, right-aligned |
| bus_ready | output | 1 | Access completion pulse |
| drv_tf_wr | output | 1 | Task-file register write strobe |
| drv_tf_rd | output | 1 | Task-file register read strobe |
| drv_tf_idx | output | 3 | Task-file register index |
| drv_ctl_wr | output | 1 | Device control write strobe |
| drv_data_wr | output | 1 | Data port write strobe |
| drv_data_rd | output | 1 | Data port read strobe |
| drv_data_wide | output | 1 | Data port access is 32 bits |
| drv_wdata | output | 32 | Write data toward the drive, byte order converted |
| drv_irq_clr | output | 1 | Status was read, so the drive clears its pending interrupt |
| drv_tf_rdata | input | 8 | Selected task-file register value |
| drv_altstat | input | 8 | Alternate status value |
| drv_data_rdata | input | 32 | Data port read value, right-aligned |

## Verification
The assertions assume the following about the host:
- `bus_rd` and `bus_wr` are never high together.
- The drive's read inputs are valid in the same cycle as the strobe that selects them.

The stimulus drives one strobe per cycle from a single task. The bench's drive model answers combinationally from its own register array, and it changes that array only on an observed write strobe.

Unmapped accesses are aimed at slots whose low three index bits name a real task-file register, such as index 15. A decoder that ignores the upper index bits would then visibly alter or return drive state.

// File: rtl/mab_pkg.sv
package mab_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_TF   = 2'd1,
      TGT_CTL  = 2'd2,
      TGT_DATA = 2'd3
   } tgt_e;
endpackage

// File: rtl/mab_decode.sv
module mab_decode
   import mab_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int TF_LAST   = 7,
   parameter int CTL_IDX   = 8,
   parameter int ALIAS_IDX = 22
) (
   input  logic [IDX_W-1:0] idx_i,
   input  size_e            size_i,
   output tgt_e             tgt_o
);
   always_comb begin
      tgt_o = TGT_NONE;
      if (size_i == SZ_BYTE) begin
         if (idx_i >= IDX_W'(1) && idx_i <= IDX_W'(TF_LAST))
            tgt_o = TGT_TF;
         else if (idx_i == IDX_W'(CTL_IDX) || idx_i == IDX_W'(ALIAS_IDX))
            tgt_o = TGT_CTL;
      end else if ((size_i == SZ_HALF || size_i == SZ_WORD) && idx_i == '0) begin
         tgt_o = TGT_DATA;
      end
   end
endmodule

// File: rtl/mab_swap.sv
module mab_swap
   import mab_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit SWAP_EN = 1'b1
) (
   input  size_e             size_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] d_o
);
   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] full_w;
   logic [DATA_W-1:0] half_w;
   logic [DATA_W-1:0] byte_w;

   generate
      if (SWAP_EN) begin : g_swap
         for (genvar b = 0; b < NB; b++) begin : g_lane
            assign full_w[8*b +: 8] = d_i[8*(NB-1-b) +: 8];
         end
         assign half_w = {{(DATA_W-16){1'b0}}, d_i[7:0], d_i[15:8]};
      end else begin : g_pass
         assign full_w = d_i;
         assign half_w = {{(DATA_W-16){1'b0}}, d_i[15:0]};
      end
   endgenerate

   assign byte_w = {{(DATA_W-8){1'b0}}, d_i[7:0]};

   always_comb begin
      case (size_i)
         SZ_BYTE: d_o = byte_w;
         SZ_HALF: d_o = half_w;
         default: d_o = full_w;
      endcase
   end
endmodule

// File: rtl/mab_resp.sv
module mab_resp #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              ready_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= '0;
         ready_o <= 1'b0;
      end else begin
         ready_o <= acc_i;
         if (rd_i)
            rdata_o <= rdata_i;
      end
   end
endmodule

// File: rtl/mmio_ata_bridge.sv
module mmio_ata_bridge
   import mab_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int IDX_LSB   = 4,
   parameter int DATA_W    = 32,
   parameter int TF_SEL_W  = 3,
   parameter int STAT_IDX  = 7,
   parameter int CTL_IDX   = 8,
   parameter int ALIAS_IDX = 22,
   parameter bit SWAP_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              drv_tf_wr,
   output logic              drv_tf_rd,
   output logic [TF_SEL_W-1:0] drv_tf_idx,
   output logic              drv_ctl_wr,
   output logic              drv_data_wr,
   output logic              drv_data_rd,
   output logic              drv_data_wide,
   output logic [DATA_W-1:0] drv_wdata,
   output logic              drv_irq_clr,
   input  logic [7:0]        drv_tf_rdata,
   input  logic [7:0]        drv_altstat,
   input  logic [DATA_W-1:0] drv_data_rdata
);
   localparam int IDX_W   = ADDR_W - IDX_LSB;
   localparam int TF_LAST = (1 << TF_SEL_W) - 1;

   generate
      if (IDX_W < 5 || ALIAS_IDX >= (1 << IDX_W)) begin : g_bad_idx
         $error("index field too narrow for the aliased control slot");
      end
      if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("data width must be a whole number of bytes, at least 32");
      end
      if (STAT_IDX > TF_LAST || CTL_IDX <= TF_LAST) begin : g_bad_map
         $error("status must be a task-file slot and control must lie above them");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             unused_low_addr;
   size_e            size;
   tgt_e             tgt;
   logic [DATA_W-1:0] wr_swapped;
   logic [DATA_W-1:0] rd_swapped;
   logic [DATA_W-1:0] rd_mux;

   assign idx             = bus_addr[ADDR_W-1:IDX_LSB];
   assign unused_low_addr = ^bus_addr[IDX_LSB-1:0];
   assign size            = size_e'(bus_size);

   mab_decode #(
      .IDX_W(IDX_W), .TF_LAST(TF_LAST), .CTL_IDX(CTL_IDX), .ALIAS_IDX(ALIAS_IDX)
   ) u_decode (
      .idx_i(idx), .size_i(size), .tgt_o(tgt)
   );

   mab_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_wswap (
      .size_i(size), .d_i(bus_wdata), .d_o(wr_swapped)
   );

   mab_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_rswap (
      .size_i(size), .d_i(drv_data_rdata), .d_o(rd_swapped)
   );

   assign drv_tf_wr     = bus_wr && (tgt == TGT_TF);
   assign drv_tf_rd     = bus_rd && (tgt == TGT_TF);
   assign drv_tf_idx    = idx[TF_SEL_W-1:0];
   assign drv_ctl_wr    = bus_wr && (tgt == TGT_CTL);
   assign drv_data_wr   = bus_wr && (tgt == TGT_DATA);
   assign drv_data_rd   = bus_rd && (tgt == TGT_DATA);
   assign drv_data_wide = (size == SZ_WORD);
   assign drv_wdata     = wr_swapped;
   assign drv_irq_clr   = drv_tf_rd && (idx == IDX_W'(STAT_IDX));

   always_comb begin
      case (tgt)
         TGT_TF:   rd_mux = {{(DATA_W-8){1'b0}}, drv_tf_rdata};
         TGT_CTL:  rd_mux = {{(DATA_W-8){1'b0}}, drv_altstat};
         TGT_DATA: rd_mux = rd_swapped;
         default: begin
            case (size)
               SZ_BYTE: rd_mux = {{(DATA_W-8){1'b0}}, 8'hFF};
               SZ_HALF: rd_mux = {{(DATA_W-16){1'b0}}, 16'hFFFF};
               default: rd_mux = '1;
            endcase
         end
      endcase
   end

   mab_resp #(.DATA_W(DATA_W)) u_resp (
      .clk(clk), .rst_n(rst_n),
      .acc_i(bus_rd || bus_wr), .rd_i(bus_rd),
      .rdata_i(rd_mux), .rdata_o(bus_rdata), .ready_o(bus_ready)
   );
endmodule

// File: rtl/mab_checker.sv
module mab_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ready,
   input logic              drv_tf_wr,
   input logic              drv_tf_rd,
   input logic [2:0]        drv_tf_idx,
   input logic              drv_ctl_wr,
   input logic              drv_data_wr,
   input logic              drv_data_rd,
   input logic              drv_data_wide,
   input logic [DATA_W-1:0] drv_wdata,
   input logic              drv_irq_clr
);
   logic [7:0] slot;
   assign slot = bus_addr[11:4];

   AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd || bus_wr) |=> bus_ready);                                   // R10
   AST_READY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |=> !bus_ready);                                 // R10
   AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_tf_wr, drv_tf_rd, drv_ctl_wr, drv_data_wr, drv_data_rd})); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |-> !(drv_tf_wr || drv_tf_rd || drv_ctl_wr
                                || drv_data_wr || drv_data_rd || drv_irq_clr)); // R9
   AST_IRQCLR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      drv_irq_clr |-> (drv_tf_rd && drv_tf_idx == 3'd7 && slot == 8'd7));  // R3
   AST_CTL_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      drv_ctl_wr |-> (bus_size == 2'd0 && (slot == 8'd8 || slot == 8'd22))); // R4
   AST_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_data_wr || drv_data_rd) |-> (slot == 8'd0 && bus_size != 2'd0
                                        && bus_size != 2'd3));             // R6
   AST_WORD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_data_wr && drv_data_wide) |->
         (drv_wdata[31:0] == {bus_wdata[7:0], bus_wdata[15:8],
                              bus_wdata[23:16], bus_wdata[31:24]}));       // R7
endmodule

bind mmio_ata_bridge mab_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mab_chk (.*);

// File: tb/mmio_ata_bridge_tb_top.sv
`timescale 1ns/1ps
module mmio_ata_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready;
   logic        drv_tf_wr, drv_tf_rd, drv_ctl_wr, drv_data_wr, drv_data_rd;
   logic        drv_data_wide, drv_irq_clr;
   logic [2:0]  drv_tf_idx;
   logic [31:0] drv_wdata;
   logic [7:0]  drv_tf_rdata;
   logic [7:0]  drv_altstat;
   logic [31:0] drv_data_rdata;

   always #10 clk = ~clk;

   mmio_ata_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .drv_tf_wr(drv_tf_wr), .drv_tf_rd(drv_tf_rd), .drv_tf_idx(drv_tf_idx),
      .drv_ctl_wr(drv_ctl_wr), .drv_data_wr(drv_data_wr),
      .drv_data_rd(drv_data_rd), .drv_data_wide(drv_data_wide),
      .drv_wdata(drv_wdata), .drv_irq_clr(drv_irq_clr),
      .drv_tf_rdata(drv_tf_rdata), .drv_altstat(drv_altstat),
      .drv_data_rdata(drv_data_rdata)
   );

   // drive-side model
   logic [7:0] tf_mem [0:7];
   int         irq_clr_cnt = 0;
   assign drv_tf_rdata   = tf_mem[drv_tf_idx];
   assign drv_altstat    = 8'h50;
   assign drv_data_rdata = 32'hA1B2_C3D4;
   initial for (int i = 0; i < 8; i++) tf_mem[i] = 8'h00;
   always @(posedge clk) begin
      if (drv_tf_wr) tf_mem[drv_tf_idx] <= drv_wdata[7:0];
      if (drv_irq_clr) irq_clr_cnt <= irq_clr_cnt + 1;
   end

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      bit          rd;
      logic [31:0] exp;
      string       req;
   } item_t;
   item_t sb_q[$];

   always @(negedge clk) begin
      if (rst_n && bus_ready) begin
         if (sb_q.size() == 0) begin
            chk("R10 stray ready", 32'd1, 32'd0);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            if (it.rd) chk(it.req, bus_rdata, it.exp);
         end
      end
   end

   // one access, held for one cycle; strobes visible 1 ns after driving
   task automatic acc(input bit rd, input logic [11:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, input logic [31:0] exp, input string req);
      item_t it;
      @(negedge clk);
      bus_rd = rd; bus_wr = !rd; bus_addr = a; bus_size = sz; bus_wdata = wd;
      it.rd = rd; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0;
      #1;
   endtask

   // {tf_wr, tf_rd, ctl_wr, data_wr, data_rd, irq_clr}
   function automatic logic [31:0] strobes();
      return {26'd0, drv_tf_wr, drv_tf_rd, drv_ctl_wr, drv_data_wr, drv_data_rd, drv_irq_clr};
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      int clr0;
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset ready", {31'd0, bus_ready}, 32'd0);
      chk("R10 reset rdata", bus_rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();

      // R2 task-file writes, R1 offset within slot
      for (int i = 1; i <= 7; i++) begin
         acc(1'b0, {4'(i), 4'(i == 3 ? 4'hB : 4'h0)}, 2'd0, 32'hABCD_0010 + i, 0, "R2 wr");
         chk("R2 tf_wr strobe", strobes(), 32'b100000);
         chk(i == 3 ? "R1 tf_idx offset" : "R2 tf_idx", {29'd0, drv_tf_idx}, i);
         chk("R2 wdata byte", {24'd0, drv_wdata[7:0]}, 32'h10 + i);
      end
      idle();
      clr0 = irq_clr_cnt;
      for (int i = 1; i <= 6; i++) begin
         acc(1'b1, {4'(i), (i == 5 ? 4'h5 : 4'h0)}, 2'd0, 0, 32'h10 + i,
             i == 5 ? "R1 rd offset" : "R2 rd");
         chk("R3 no clr on tf read", strobes(), 32'b010000);
      end
      acc(1'b1, 12'h070, 2'd0, 0, 32'h17, "R2 status rd");
      chk("R3 status clr", strobes(), 32'b010001);
      idle();
      chk("R3 clr count", irq_clr_cnt - clr0, 1);

      // R4 control writes at both slots
      acc(1'b0, 12'h080, 2'd0, 32'h0000_0006, 0, "R4 wr");
      chk("R4 ctl strobe 8", strobes(), 32'b001000);
      chk("R4 ctl data 8", {24'd0, drv_wdata[7:0]}, 32'h06);
      acc(1'b0, 12'h16C, 2'd0, 32'h0000_0002, 0, "R4 wr");
      chk("R4 ctl strobe 22", strobes(), 32'b001000);
      chk("R4 ctl data 22", {24'd0, drv_wdata[7:0]}, 32'h02);

      // R5 alternate status reads
      clr0 = irq_clr_cnt;
      acc(1'b1, 12'h080, 2'd0, 0, 32'h50, "R5 alt 8");
      chk("R5 alt 8 quiet", strobes(), 32'b000000);
      acc(1'b1, 12'h160, 2'd0, 0, 32'h50, "R5 alt 22");
      chk("R5 alt 22 quiet", strobes(), 32'b000000);
      idle();
      chk("R5 clr count", irq_clr_cnt - clr0, 0);

      // R6 halfword data port
      acc(1'b0, 12'h000, 2'd1, 32'h0000_1234, 0, "R6 wr");
      chk("R6 data_wr strobe", strobes(), 32'b000100);
      chk("R6 narrow", {31'd0, drv_data_wide}, 32'd0);
      chk("R6 wdata swap", {16'd0, drv_wdata[15:0]}, 32'h3412);
      acc(1'b1, 12'h002, 2'd1, 0, 32'h0000_D4C3, "R6 rd swap");
      chk("R6 data_rd strobe", strobes(), 32'b000010);

      // R7 word data port
      acc(1'b0, 12'h000, 2'd2, 32'h1122_3344, 0, "R7 wr");
      chk("R7 wide", {31'd0, drv_data_wide}, 32'd1);
      chk("R7 wdata swap", drv_wdata, 32'h4433_2211);
      acc(1'b1, 12'h000, 2'd2, 0, 32'hD4C3_B2A1, "R7 rd swap");
      chk("R7 data_rd strobe", strobes(), 32'b000010);

      // R8 unmapped reads
      acc(1'b1, 12'h000, 2'd0, 0, 32'h0000_00FF, "R8 byte idx0");
      chk("R8 byte idx0 quiet", strobes(), 0);
      acc(1'b1, 12'h0F0, 2'd0, 0, 32'h0000_00FF, "R8 byte idx15");
      chk("R8 byte idx15 quiet", strobes(), 0);
      acc(1'b1, 12'h090, 2'd0, 0, 32'h0000_00FF, "R8 byte idx9");
      acc(1'b1, 12'h010, 2'd1, 0, 32'h0000_FFFF, "R8 half idx1");
      acc(1'b1, 12'h050, 2'd2, 0, 32'hFFFF_FFFF, "R8 word idx5");
      acc(1'b1, 12'h000, 2'd3, 0, 32'hFFFF_FFFF, "R8 size3 idx0");
      acc(1'b1, 12'hFF0, 2'd0, 0, 32'h0000_00FF, "R8 byte idx255");

      // R9 unmapped writes
      acc(1'b0, 12'h0F0, 2'd0, 32'h0000_00EE, 0, "R9 wr");
      chk("R9 byte idx15 quiet", strobes(), 0);
      acc(1'b0, 12'h020, 2'd1, 32'h0000_EEEE, 0, "R9 wr");
      chk("R9 half idx2 quiet", strobes(), 0);
      acc(1'b0, 12'h070, 2'd2, 32'hEEEE_EEEE, 0, "R9 wr");
      chk("R9 word idx7 quiet", strobes(), 0);
      acc(1'b0, 12'h000, 2'd0, 32'h0000_00EE, 0, "R9 wr");
      chk("R9 byte idx0 quiet", strobes(), 0);
      acc(1'b0, 12'h070, 2'd3, 32'h0000_00EE, 0, "R9 wr");
      chk("R9 size3 quiet", strobes(), 0);
      acc(1'b1, 12'h070, 2'd0, 0, 32'h17, "R9 tf7 unchanged");
      acc(1'b1, 12'h020, 2'd0, 0, 32'h12, "R9 tf2 unchanged");
      idle();

      // R10 ready drops when idle
      @(negedge clk);
      chk("R10 ready idle", {31'd0, bus_ready}, 32'd0);
      chk("R10 queue drained", sb_q.size(), 0);

      done = 1'b1;
      finish_run();
   end
endmodule